// File: doc/BRIEF.md
# Masked Packed Funnel-Shift-Left Unit

The unit is a SIMD datapath with a single register stage. It cuts a destination vector and a second source vector into lanes of 16, 32 or 64 bits. For every lane it places the destination element above the second-source element to form a double-width value. It shifts that value left by a count taken from a third vector and keeps only the upper half. The result for one lane is therefore the destination element with its low end refilled from the top bits of the second source.

A per-lane write mask chooses which lanes take the new value. A masked-off lane is either cleared (zero mode) or keeps the incoming destination element (merge mode). For 32-bit and 64-bit lanes, the count can be broadcast from element 0 of the count vector. A vector-length select limits the active width to 128, 256 or 512 bits, and every result bit above the active width reads zero. The registered result appears one clock after the inputs are presented.

Top module: `funnel_shl_simd`

## Requirements
- R1: For an active, written lane, the result is the upper half of {destination element, second-source element} shifted left by the lane's count. Example: for a 16-bit lane, 16'h1234 with 16'hABCD and count 4 gives 16'h234A.
- R2: Only the low bits of each count are used, so the count is taken modulo the lane width. These are bits [3:0] for 16-bit lanes, [4:0] for 32-bit lanes and [5:0] for 64-bit lanes.
- R3: elem_size selects the lane width: 0 = 16 bits, 1 = 32 bits, 2 = 64 bits. Lane j occupies bits [j*W +: W] of every vector and uses kmask bit j. Code 3 is reserved and makes the whole result zero.
- R4: When mask_en is 0, every active lane is written with its shifted value, whatever kmask and zero_en hold.
- R5: When mask_en is 1, zero_en is 1 and a lane's kmask bit is 0, that lane reads zero.
- R6: When mask_en is 1, zero_en is 0 and a lane's kmask bit is 0, that lane equals its destination element.
- R7: With bcast = 1 and 32-bit or 64-bit lanes, every lane uses element 0 of src3 (bits [W-1:0]) as its count.
- R8: With bcast = 1 and 16-bit lanes, the broadcast request is ignored and each lane uses its own count element.
- R9: vl_sel selects the active width: 0 = 128 bits, 1 = 256 bits, 2 or 3 = 512 bits. Every result bit at or above the active width is zero.
- R10: result is registered. It reflects the inputs of the previous clock edge and is all zero while rst_n is low.
- R11: A lane count of zero (after the modulo) returns the destination element unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the result register |
| dest_in | input | 512 | Destination vector, upper half of each lane pair, also the merge value |
| src2 | input | 512 | Second source vector, lower half of each lane pair |
| src3 | input | 512 | Per-lane shift counts |
| kmask | input | 32 | Per-lane write mask, bit j for lane j |
| elem_size | input | 2 | Lane width code |
| vl_sel | input | 2 | Active vector width code |
| mask_en | input | 1 | Enables write masking |
| zero_en | input | 1 | Masked-off lanes read zero instead of merging |
| bcast | input | 1 | Use count element 0 for all lanes (32/64-bit lanes) |
| result | output | 512 | Registered result |

## Verification
Each lane is pure logic feeding one register, so any internal error shows at result on the very next clock. The error stays confined to the bits of the affected lanes or of the inactive region. A wrong lane-width or width decode shifts lane boundaries and corrupts many lanes at once. A wrong count slice only appears when a count reaches or exceeds the lane width, so the tests deliberately use counts of W, W+1 and all-ones. A broadcast or merge fault only appears when per-lane counts differ or mask bits are clear. The directed tasks therefore set up exactly those conditions and compare every bit of the result against an independent lane-by-lane model.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  typedef enum logic [1:0] {
    ESZ_W16  = 2'd0,
    ESZ_W32  = 2'd1,
    ESZ_W64  = 2'd2,
    ESZ_RSVD = 2'd3
  } esz_e;

  // Active width in bits for a vector-length code, given the maximum width.
  function automatic int fsl_active_bits(input logic [1:0] vl, input int vw);
    case (vl)
      2'd0:    return vw / 4;
      2'd1:    return vw / 2;
      default: return vw;
    endcase
  endfunction

endpackage

// File: rtl/fsl_lane_bank.sv
module fsl_lane_bank #(
  parameter int VW = 512,
  parameter int EW = 16
) (
  input  logic [VW-1:0]    dest_in,
  input  logic [VW-1:0]    src2,
  input  logic [VW-1:0]    src3,
  input  logic [VW/EW-1:0] kmask,
  input  logic [1:0]       vl_sel,
  input  logic             mask_en,
  input  logic             zero_en,
  input  logic             bcast,
  output logic [VW-1:0]    lane_out
);
  localparam int LANES = VW / EW;
  localparam logic [EW-1:0] EW_L    = EW'(EW);
  localparam logic [EW-1:0] EW_MASK = EW'(EW - 1);

  // Funnel left: upper half of {hi,lo} << (cnt mod EW).
  function automatic logic [EW-1:0] funnel(input logic [EW-1:0] hi,
                                           input logic [EW-1:0] lo,
                                           input logic [EW-1:0] cnt);
    logic [EW-1:0] n;
    n = cnt & EW_MASK;
    if (n == '0) return hi;
    return (hi << n) | (lo >> (EW_L - n));
  endfunction

  int   act_bits;
  logic use_bc;

  assign act_bits = fsl_pkg::fsl_active_bits(vl_sel, VW);
  assign use_bc   = bcast & (EW != 16);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [EW-1:0] d_e, s_e, c_e, sh_e;
    logic          lane_on, wr;

    assign d_e     = dest_in[j*EW +: EW];
    assign s_e     = src2[j*EW +: EW];
    assign c_e     = use_bc ? src3[EW-1:0] : src3[j*EW +: EW];
    assign sh_e    = funnel(d_e, s_e, c_e);
    assign lane_on = (j * EW) < act_bits;
    assign wr      = ~mask_en | kmask[j];

    assign lane_out[j*EW +: EW] = !lane_on ? '0 :
                                  wr       ? sh_e :
                                  zero_en  ? '0 : d_e;
  end

endmodule

// File: rtl/fsl_select.sv
module fsl_select #(
  parameter int VW = 512
) (
  input  logic [1:0]    elem_size,
  input  logic [VW-1:0] v16,
  input  logic [VW-1:0] v32,
  input  logic [VW-1:0] v64,
  output logic [VW-1:0] vsel,
  output logic          size_bad
);
  import fsl_pkg::*;

  always_comb begin
    size_bad = 1'b0;
    case (esz_e'(elem_size))
      ESZ_W16: vsel = v16;
      ESZ_W32: vsel = v32;
      ESZ_W64: vsel = v64;
      default: begin
        vsel     = '0;
        size_bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/funnel_shl_simd.sv
module funnel_shl_simd #(
  parameter int VW = 512,
  parameter int KW = VW / 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] dest_in,
  input  logic [VW-1:0] src2,
  input  logic [VW-1:0] src3,
  input  logic [KW-1:0] kmask,
  input  logic [1:0]    elem_size,
  input  logic [1:0]    vl_sel,
  input  logic          mask_en,
  input  logic          zero_en,
  input  logic          bcast,
  output logic [VW-1:0] result
);
  localparam int L32 = VW / 32;
  localparam int L64 = VW / 64;

  logic [VW-1:0] bank16, bank32, bank64, next_res;
  logic          size_bad;

  fsl_lane_bank #(.VW(VW), .EW(16)) u_b16 (
    .dest_in(dest_in), .src2(src2), .src3(src3), .kmask(kmask),
    .vl_sel(vl_sel), .mask_en(mask_en), .zero_en(zero_en), .bcast(bcast),
    .lane_out(bank16));

  fsl_lane_bank #(.VW(VW), .EW(32)) u_b32 (
    .dest_in(dest_in), .src2(src2), .src3(src3), .kmask(kmask[L32-1:0]),
    .vl_sel(vl_sel), .mask_en(mask_en), .zero_en(zero_en), .bcast(bcast),
    .lane_out(bank32));

  fsl_lane_bank #(.VW(VW), .EW(64)) u_b64 (
    .dest_in(dest_in), .src2(src2), .src3(src3), .kmask(kmask[L64-1:0]),
    .vl_sel(vl_sel), .mask_en(mask_en), .zero_en(zero_en), .bcast(bcast),
    .lane_out(bank64));

  fsl_select #(.VW(VW)) u_sel (
    .elem_size(elem_size), .v16(bank16), .v32(bank32), .v64(bank64),
    .vsel(next_res), .size_bad(size_bad));

  always_ff @(posedge clk) begin
    if (!rst_n) result <= '0;
    else        result <= next_res;
  end

endmodule

// File: rtl/fsl_checker.sv
module fsl_checker #(
  parameter int VW = 512,
  parameter int KW = VW / 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [VW-1:0] dest_in,
  input logic [VW-1:0] src3,
  input logic [KW-1:0] kmask,
  input logic [1:0]    elem_size,
  input logic [1:0]    vl_sel,
  input logic          mask_en,
  input logic          zero_en,
  input logic          size_bad,
  input logic [VW-1:0] result
);

  assert_vl128_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vl_sel == 2'd0 |=> result[VW-1:VW/4] == '0);

  assert_vl256_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vl_sel == 2'd1 |=> result[VW-1:VW/2] == '0);

  assert_rsvd_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    size_bad |=> result == '0);

  assert_zero_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && zero_en && kmask == '0) |=> result == '0);

  assert_merge_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && !zero_en && kmask == '0 && vl_sel[1] && elem_size != 2'd3)
    |=> result == $past(dest_in));

  assert_count_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_en && src3 == '0 && vl_sel[1] && elem_size != 2'd3)
    |=> result == $past(dest_in));

endmodule

bind funnel_shl_simd fsl_checker #(.VW(VW), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dest_in(dest_in), .src3(src3), .kmask(kmask),
  .elem_size(elem_size), .vl_sel(vl_sel), .mask_en(mask_en),
  .zero_en(zero_en), .size_bad(size_bad), .result(result));

// File: tb/sim_funnel_shl_simd.sv
`timescale 1ns/1ps
module sim_funnel_shl_simd;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [511:0] dest_in = '0, src2 = '0, src3 = '0;
  logic [31:0]  kmask = '0;
  logic [1:0]   elem_size = '0, vl_sel = 2'd2;
  logic         mask_en = 1'b0, zero_en = 1'b0, bcast = 1'b0;
  logic [511:0] result;
  int checks = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  funnel_shl_simd u0 (
    .clk(clk), .rst_n(rst_n), .dest_in(dest_in), .src2(src2), .src3(src3),
    .kmask(kmask), .elem_size(elem_size), .vl_sel(vl_sel), .mask_en(mask_en),
    .zero_en(zero_en), .bcast(bcast), .result(result));

  // Lane-by-lane model using a double-width concatenation.
  function automatic logic [511:0] model(input logic [511:0] d, s, c,
      input logic [31:0] k, input logic [1:0] es, vl,
      input logic me, ze, bc);
    logic [511:0] r = '0;
    int ew, vb, nl;
    if (es == 2'd3) return '0;
    ew = 16 << es;
    vb = (vl == 0) ? 128 : (vl == 1) ? 256 : 512;
    nl = vb / ew;
    for (int j = 0; j < nl; j++) begin
      logic [63:0] m, de, se, ce, lane;
      logic [127:0] cat;
      int n;
      m  = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
      de = (d >> (j*ew)) & m;
      se = (s >> (j*ew)) & m;
      ce = (bc && es != 0) ? (c[63:0] & m) : ((c >> (j*ew)) & m);
      n  = int'(ce % ew);
      cat = (({64'd0, de} << ew) | {64'd0, se}) << n;
      if (!me || k[j])  lane = (cat >> ew) & {64'd0, m};
      else if (ze)      lane = '0;
      else              lane = de;
      r |= {448'd0, lane} << (j*ew);
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [511:0] act, exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [511:0] d, s, c,
      input logic [31:0] k, input logic [1:0] es, vl,
      input logic me, ze, bc);
    logic [511:0] exp;
    @(negedge clk);
    dest_in = d; src2 = s; src3 = c; kmask = k; elem_size = es;
    vl_sel = vl; mask_en = me; zero_en = ze; bcast = bc;
    exp = model(d, s, c, k, es, vl, me, ze, bc);
    @(negedge clk);
    check(tag, result, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    dest_in = '1; src2 = '1; src3 = '0;
    @(negedge clk);
    check("R10 reset", result, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_example();
    logic [511:0] d = '0, s = '0, c = '0;
    d[15:0] = 16'h1234; s[15:0] = 16'hABCD; c[15:0] = 16'd4;
    run("R1 hand example", d, s, c, '0, 2'd0, 2'd2, 0, 0, 0);
    check("R1 lane0 value", {496'd0, result[15:0]}, {496'd0, 16'h234A});
  endtask

  task automatic t_sizes();
    for (int es = 0; es < 3; es++)
      run("R1 R3 R4 size sweep", rnd512(), rnd512(), rnd512(), $urandom,
          2'(es), 2'd2, 0, 1, 0);
  endtask

  task automatic t_counts();
    int cl[6] = '{0, 15, 16, 17, 31, 65535};
    for (int i = 0; i < 6; i++) begin
      logic [511:0] c;
      for (int j = 0; j < 32; j++) c[j*16 +: 16] = 16'(cl[i] + j);
      run("R2 counts 16", rnd512(), rnd512(), c, '0, 2'd0, 2'd2, 0, 0, 0);
      run("R2 counts 32", rnd512(), rnd512(), c, '0, 2'd1, 2'd2, 0, 0, 0);
      run("R2 counts 64", rnd512(), rnd512(), c, '0, 2'd2, 2'd2, 0, 0, 0);
    end
  endtask

  task automatic t_zero_count();
    logic [511:0] d = rnd512();
    logic [511:0] c = '0;
    for (int j = 0; j < 8; j++) c[j*64 +: 64] = 64'd64 * (j + 1);
    run("R11 count zero", d, rnd512(), c, '0, 2'd2, 2'd2, 0, 0, 0);
    check("R11 dest kept", result, d);
  endtask

  task automatic t_masks();
    run("R5 zero mode", rnd512(), rnd512(), rnd512(), 32'hA5C3_0F96, 2'd0, 2'd2, 1, 1, 0);
    run("R5 zero mode 64", rnd512(), rnd512(), rnd512(), 32'h0000_0055, 2'd2, 2'd2, 1, 1, 0);
    run("R6 merge mode", rnd512(), rnd512(), rnd512(), 32'h5A3C_F069, 2'd1, 2'd2, 1, 0, 0);
    run("R6 merge all off", rnd512(), rnd512(), rnd512(), 32'h0, 2'd0, 2'd2, 1, 0, 0);
    run("R4 mask disabled", rnd512(), rnd512(), rnd512(), 32'h0, 2'd1, 2'd2, 0, 1, 0);
  endtask

  task automatic t_bcast();
    logic [511:0] c = rnd512();
    run("R7 broadcast 32", rnd512(), rnd512(), c, '1, 2'd1, 2'd2, 0, 0, 1);
    run("R7 broadcast 64", rnd512(), rnd512(), c, '1, 2'd2, 2'd2, 0, 0, 1);
    run("R8 broadcast 16 ignored", rnd512(), rnd512(), c, '1, 2'd0, 2'd2, 0, 0, 1);
  endtask

  task automatic t_vl();
    for (int v = 0; v < 4; v++) begin
      run("R9 width 16", rnd512(), rnd512(), rnd512(), $urandom, 2'd0, 2'(v), 1, 0, 0);
      run("R9 width 64", rnd512(), rnd512(), rnd512(), $urandom, 2'd2, 2'(v), 0, 0, 1);
    end
  endtask

  task automatic t_rsvd();
    run("R3 reserved size", rnd512(), rnd512(), rnd512(), '1, 2'd3, 2'd2, 0, 0, 0);
    check("R3 reserved zero", result, '0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 80; i++)
      run("R1 R7 R9 random", rnd512(), rnd512(), rnd512(), $urandom,
          2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)),
          1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_example();
    t_sizes();
    t_counts();
    t_zero_count();
    t_masks();
    t_bcast();
    t_vl();
    t_rsvd();
    t_random();
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule